// File: doc/BRIEF.md
# Per-Core One-Shot Event Timer

This block is the private timer of a single processor core. The core reaches it through a small control-register port: a register select, a write strobe, write data and combinational read data. There is no memory-mapped bus decode. Two independent functions share the port. The first is a free-running up-counter that software reads as a continuous time base. The second is a one-shot event timer that raises a level interrupt once a programmed number of clocks has elapsed.

Software enables event operation through the control register. It arms an event by writing an interval to the load register. When the interrupt fires, software clears it by writing zero to the status register. Each core has its own copy, and every copy drives the same private interrupt number (16) at its own interrupt controller. That replication, the clock source and the controller are outside this block.

Top module: `pcore_evt_timer`

## Requirements
- R1: After reset, `count_o` is 0, `irq_o` is 0, and reads of select 0 (control) and select 1 (status) return 0.
- R2: The counter starts from 0 after reset and grows by exactly one on every clock, modulo 2^DATA_W, whatever the timer state. It is visible on `count_o` and as read data at select 3.
- R3: Select 0 is the control register. Write data bit 0 sets the enable, and a read returns the enable in bit 0 with all other bits zero.
- R4: A write of N (2 to 2^DATA_W-1) to select 6 (load) while enabled sets `irq_o` exactly N clocks after the clock edge that takes the write. A read of select 6 returns the last accepted interval.
- R5: A write to select 6 while disabled is ignored: no event is armed and the select 6 readback does not change.
- R6: `irq_o` is a level that stays high until a write of all-zero data to select 1. A read of select 1 returns the pending flag in bit 0, and writes of nonzero data to select 1 are ignored.
- R7: The timer is one-shot. After an expiry has been cleared, no further interrupt occurs until a new load write.
- R8: A load write while a countdown is running restarts the countdown from the new interval and discards the earlier expiry.
- R9: Writing 0 to the control register drops any running countdown, including one that would expire on that same edge. Re-enabling does not resume the dropped countdown, and the counter keeps counting.
- R10: Reads of any select other than 0, 1, 3 and 6 return zero, and writes to those selects change no state.
- R11: When an expiry and a status clear land on the same clock edge, the expiry wins and `irq_o` goes high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Timer input clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_sel | input | SEL_W | Register select |
| reg_we | input | 1 | Write strobe for the selected register |
| reg_wdata | input | DATA_W | Write data |
| reg_rdata | output | DATA_W | Read data for the selected register, combinational |
| count_o | output | DATA_W | Free-running counter value |
| irq_o | output | 1 | Level interrupt, pending event status |

## Verification
The checker watches several rules on every cycle: the counter's one-per-clock step, the interrupt holding high until a zero write to the status select, the quiet cycle after a disable write, zero read data on unimplemented selects, and status and control readback agreeing with the pin and with the enable bit's position. The exact expiry cycle for a given interval can only be shown by the bench scenarios. The same goes for a reload discarding the older event, a dropped countdown staying dropped across re-enable, the ignored load while disabled, and the priority of an expiry over a clear on the same edge.

// File: rtl/ptm_pkg.sv
package ptm_pkg;
   localparam int unsigned SEL_CTRL  = 0;
   localparam int unsigned SEL_STAT  = 1;
   localparam int unsigned SEL_COUNT = 3;
   localparam int unsigned SEL_LOAD  = 6;

   typedef struct packed {
      logic ctrl;
      logic stat;
      logic load;
   } ptm_wstb_t;
endpackage

// File: rtl/ptm_decode.sv
module ptm_decode
   import ptm_pkg::*;
#(
   parameter int unsigned SEL_W = 4
) (
   input  logic [SEL_W-1:0] sel_i,
   input  logic             we_i,
   output ptm_wstb_t        wstb_o
);
   always_comb begin
      wstb_o.ctrl = we_i && (sel_i == SEL_W'(SEL_CTRL));
      wstb_o.stat = we_i && (sel_i == SEL_W'(SEL_STAT));
      wstb_o.load = we_i && (sel_i == SEL_W'(SEL_LOAD));
   end
endmodule

// File: rtl/ptm_freerun.sv
module ptm_freerun #(
   parameter int unsigned W = 32
) (
   input  logic         clk,
   input  logic         rst_n,
   output logic [W-1:0] count_o
);
   logic [W-1:0] count_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) count_q <= '0;
      else        count_q <= count_q + W'(1);
   end

   assign count_o = count_q;
endmodule

// File: rtl/ptm_oneshot.sv
module ptm_oneshot
   import ptm_pkg::*;
#(
   parameter int unsigned W = 32
) (
   input  logic         clk,
   input  logic         rst_n,
   input  ptm_wstb_t    wstb_i,
   input  logic [W-1:0] wdata_i,
   output logic         en_o,
   output logic         status_o,
   output logic [W-1:0] load_o
);
   logic         en_q, armed_q, status_q;
   logic [W-1:0] rem_q, load_q;
   logic         stop_wr, reload, hit, fire;

   // a disable write or an accepted reload both cancel this edge's expiry
   assign stop_wr = wstb_i.ctrl && !wdata_i[0];
   assign reload  = wstb_i.load && en_q;
   assign hit     = armed_q && (rem_q == W'(1));
   assign fire    = hit && !stop_wr && !reload;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         en_q    <= 1'b0;
         armed_q <= 1'b0;
         rem_q   <= '0;
         load_q  <= '0;
      end else begin
         if (wstb_i.ctrl) en_q <= wdata_i[0];
         if (stop_wr) begin
            armed_q <= 1'b0;
         end else if (reload) begin
            armed_q <= 1'b1;
            rem_q   <= wdata_i;
            load_q  <= wdata_i;
         end else if (armed_q) begin
            if (hit) armed_q <= 1'b0;
            else     rem_q   <= rem_q - W'(1);
         end
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                                status_q <= 1'b0;
      else if (fire)                             status_q <= 1'b1;
      else if (wstb_i.stat && (wdata_i == '0))   status_q <= 1'b0;
   end

   assign en_o     = en_q;
   assign status_o = status_q;
   assign load_o   = load_q;
endmodule

// File: rtl/pcore_evt_timer.sv
module pcore_evt_timer
   import ptm_pkg::*;
#(
   parameter int unsigned DATA_W = 32,
   parameter int unsigned SEL_W  = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [SEL_W-1:0]  reg_sel,
   input  logic              reg_we,
   input  logic [DATA_W-1:0] reg_wdata,
   output logic [DATA_W-1:0] reg_rdata,
   output logic [DATA_W-1:0] count_o,
   output logic              irq_o
);
   localparam int unsigned PAD_W = DATA_W - 1;

   if (DATA_W < 2) begin : g_bad_width
      $error("pcore_evt_timer: DATA_W must be at least 2");
   end
   if (SEL_W < 3) begin : g_bad_sel
      $error("pcore_evt_timer: SEL_W must reach select 6");
   end

   ptm_wstb_t         wstb;
   logic              en;
   logic              status;
   logic [DATA_W-1:0] load_val;
   logic [DATA_W-1:0] count;

   ptm_decode #(.SEL_W(SEL_W)) u_decode (
      .sel_i  (reg_sel),
      .we_i   (reg_we),
      .wstb_o (wstb)
   );

   ptm_freerun #(.W(DATA_W)) u_freerun (
      .clk     (clk),
      .rst_n   (rst_n),
      .count_o (count)
   );

   ptm_oneshot #(.W(DATA_W)) u_oneshot (
      .clk      (clk),
      .rst_n    (rst_n),
      .wstb_i   (wstb),
      .wdata_i  (reg_wdata),
      .en_o     (en),
      .status_o (status),
      .load_o   (load_val)
   );

   always_comb begin
      case (reg_sel)
         SEL_W'(SEL_CTRL):  reg_rdata = {{PAD_W{1'b0}}, en};
         SEL_W'(SEL_STAT):  reg_rdata = {{PAD_W{1'b0}}, status};
         SEL_W'(SEL_COUNT): reg_rdata = count;
         SEL_W'(SEL_LOAD):  reg_rdata = load_val;
         default:           reg_rdata = '0;
      endcase
   end

   assign count_o = count;
   assign irq_o   = status;
endmodule

// File: rtl/ptm_chk.sv
module ptm_chk
   import ptm_pkg::*;
#(
   parameter int unsigned DATA_W = 32,
   parameter int unsigned SEL_W  = 4
) (
   input logic              clk,
   input logic              rst_n,
   input logic [SEL_W-1:0]  reg_sel,
   input logic              reg_we,
   input logic [DATA_W-1:0] reg_wdata,
   input logic [DATA_W-1:0] reg_rdata,
   input logic [DATA_W-1:0] count_o,
   input logic              irq_o
);
   logic seen_q;
   logic sel_known;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) seen_q <= 1'b0;
      else        seen_q <= 1'b1;
   end

   assign sel_known = (reg_sel == SEL_W'(SEL_CTRL)) || (reg_sel == SEL_W'(SEL_STAT)) ||
                      (reg_sel == SEL_W'(SEL_COUNT)) || (reg_sel == SEL_W'(SEL_LOAD));

   // R2
   count_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
      seen_q |=> (count_o - $past(count_o)) == DATA_W'(1));

   // R6
   irq_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (irq_o && !(reg_we && reg_sel == SEL_W'(SEL_STAT) && reg_wdata == '0)) |=> irq_o);

   // R6
   status_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (reg_sel == SEL_W'(SEL_STAT)) |-> (reg_rdata == {{(DATA_W-1){1'b0}}, irq_o}));

   // R3
   ctrl_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (reg_sel == SEL_W'(SEL_CTRL)) |-> (reg_rdata[DATA_W-1:1] == '0));

   // R9
   disable_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (reg_we && reg_sel == SEL_W'(SEL_CTRL) && !reg_wdata[0] && !irq_o) |=> !irq_o);

   // R10
   unimpl_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !sel_known |-> (reg_rdata == '0));
endmodule

bind pcore_evt_timer ptm_chk #(.DATA_W(DATA_W), .SEL_W(SEL_W)) u_ptm_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .reg_sel   (reg_sel),
   .reg_we    (reg_we),
   .reg_wdata (reg_wdata),
   .reg_rdata (reg_rdata),
   .count_o   (count_o),
   .irq_o     (irq_o)
);

// File: tb/test_pcore_evt_timer.sv
module test_pcore_evt_timer;
   localparam int CLK_PERIOD = 10;
   localparam int DW = 32;
   localparam int SW = 4;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic [SW-1:0] reg_sel = '0;
   logic          reg_we = 1'b0;
   logic [DW-1:0] reg_wdata = '0;
   logic [DW-1:0] reg_rdata;
   logic [DW-1:0] count_o;
   logic          irq_o;

   pcore_evt_timer #(.DATA_W(DW), .SEL_W(SW)) i_pcore_evt_timer (
      .clk(clk), .rst_n(rst_n), .reg_sel(reg_sel), .reg_we(reg_we),
      .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .count_o(count_o), .irq_o(irq_o)
   );

   always #(CLK_PERIOD/2) clk = ~clk;

   typedef struct {
      int          kind;   // 0 read data, 1 irq pin, 2 counter pin
      logic [DW-1:0] exp;
      string       tag;
   } item_t;

   item_t q[$];
   event  smp_ev;
   int    checks = 0;
   int    errors = 0;
   bit    done = 1'b0;
   logic [DW-1:0] model_cnt = '0;

   // counter model: one step per clock after reset release
   always @(posedge clk) begin
      if (!rst_n) model_cnt <= '0;
      else        model_cnt <= model_cnt + 1;
   end

   // monitor: pops expected items and compares to the pins
   initial begin
      forever begin
         item_t it;
         logic [DW-1:0] act;
         @(smp_ev);
         while (q.size() > 0) begin
            it = q.pop_front();
            case (it.kind)
               0: act = reg_rdata;
               1: act = {{(DW-1){1'b0}}, irq_o};
               default: act = count_o;
            endcase
            checks++;
            if (act !== it.exp) begin
               errors++;
               $display("FAIL %s: actual %0h expected %0h", it.tag, act, it.exp);
            end
         end
      end
   end

   task automatic push(input int kind, input logic [DW-1:0] exp, input string tag);
      item_t it;
      it.kind = kind; it.exp = exp; it.tag = tag;
      q.push_back(it);
      #1;
      ->smp_ev;
      #1;
   endtask

   task automatic idle(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic wr(input int sel, input logic [DW-1:0] d);
      reg_sel = SW'(sel); reg_wdata = d; reg_we = 1'b1;
      @(negedge clk);
      reg_we = 1'b0; reg_wdata = '0;
   endtask

   task automatic rd(input int sel, input logic [DW-1:0] exp, input string tag);
      reg_sel = SW'(sel);
      push(0, exp, tag);
      @(negedge clk);
   endtask

   task automatic chk_irq(input logic v, input string tag);
      push(1, {{(DW-1){1'b0}}, v}, tag);
   endtask

   initial begin
      #(CLK_PERIOD * 20000);
      if (!done) begin
         errors++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

   initial begin
      idle(3);
      rst_n = 1'b1;
      // R1 reset state
      push(2, '0, "R1 counter at reset");
      chk_irq(1'b0, "R1 irq at reset");
      rd(0, '0, "R1 control at reset");
      rd(1, '0, "R1 status at reset");
      // R2 counter steps
      idle(3);
      push(2, model_cnt, "R2 counter pin");
      rd(3, model_cnt, "R2 counter read select 3");

      // R5 load while disabled
      wr(6, 5);
      idle(8);
      chk_irq(1'b0, "R5 no event when disabled");
      rd(6, '0, "R5 load readback unchanged");

      // R3 enable readback, R4 interval 5
      wr(0, 32'hFFFF_FFFF);
      rd(0, 1, "R3 control reads bit0 only");
      wr(6, 5);
      idle(4);
      chk_irq(1'b0, "R4 not yet at N-1");
      idle(1);
      chk_irq(1'b1, "R4 fires at N");
      rd(1, 1, "R6 status reads pending");
      rd(6, 5, "R4 load readback");

      // R6 level hold, nonzero clear ignored
      wr(1, 1);
      chk_irq(1'b1, "R6 nonzero write ignored");
      idle(3);
      chk_irq(1'b1, "R6 level holds");
      wr(1, 0);
      chk_irq(1'b0, "R6 cleared by zero write");
      idle(10);
      chk_irq(1'b0, "R7 one-shot no repeat");

      // R8 reload discards earlier expiry
      wr(6, 100);
      idle(20);
      wr(6, 7);
      idle(6);
      chk_irq(1'b0, "R8 restarted, not yet");
      idle(1);
      chk_irq(1'b1, "R8 fires on new interval");
      wr(1, 0);
      idle(90);
      chk_irq(1'b0, "R8 old expiry discarded");

      // R9 disable drops countdown
      wr(6, 10);
      idle(3);
      wr(0, 0);
      idle(15);
      chk_irq(1'b0, "R9 dropped while disabled");
      wr(0, 1);
      idle(15);
      chk_irq(1'b0, "R9 not resumed on re-enable");
      push(2, model_cnt, "R2 counter unaffected by disable");

      // R4 minimum interval 2
      wr(6, 2);
      idle(1);
      chk_irq(1'b0, "R4 min interval early");
      idle(1);
      chk_irq(1'b1, "R4 min interval fires");
      wr(1, 0);

      // R10 unimplemented selects
      rd(2, '0, "R10 select 2 reads zero");
      rd(7, '0, "R10 select 7 reads zero");
      rd(15, '0, "R10 select 15 reads zero");
      wr(2, 32'hFFFF_FFFF);
      wr(5, 32'h1);
      wr(4, 32'h0);
      rd(0, 1, "R10 control untouched");
      rd(6, 2, "R10 load untouched");
      chk_irq(1'b0, "R10 no event from stray write");

      // R11 expiry and clear on the same edge
      wr(6, 6);
      idle(5);
      wr(1, 0);
      chk_irq(1'b1, "R11 expiry wins over clear");
      wr(1, 0);
      chk_irq(1'b0, "R11 later clear works");

      idle(2);
      if (q.size() != 0) begin
         errors++;
         $display("FAIL scoreboard: actual %0d left expected 0", q.size());
      end
      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule